// File: doc/BRIEF.md
# Precision-Aware Operand Scheduler

This unit sits in front of a variable-precision multiplier. It accepts a batch of operand pairs. For each pair it works out how many bits the values really need: 8, 16 or 32. It stores the pair in a buffer region kept for that precision class. Once the batch is closed, it issues the pairs one class at a time, in the order 8, 16, 32. Before each class group it looks up the operating point for that class and drives it to the supply and clock generators. The operating point is a voltage code and a 4-bit frequency code.

Grouping pairs of the same class means the operating point moves at most once per class in each batch, instead of once per pair. A two-bit policy input chooses how the operating point follows the class:

- Policy A: both voltage and frequency track the class.
- Policy B: voltage is pinned and only the frequency tracks the class.
- Policy C: voltage is pinned and the frequency runs opposite to policy A.

Each issued pair carries a tag holding its arrival index, so that downstream logic can restore the original order of results. When the operating point changes, the unit pulses a strobe. It then waits one settle cycle before it issues again.

Top module: `opsched_top`

## Requirements
- R1: A pair is class 8 (out_prec=0) when both operands lie in -128..127. Otherwise it is class 16 (out_prec=1) when both lie in -32768..32767. Otherwise it is class 32 (out_prec=2).
- R2: in_ready is high only while collecting. A batch closes on the pair accepted with in_last=1, or on the D-th accepted pair. While the batch is issuing, in_ready is low and in_valid is ignored: a pair offered then is never stored or issued.
- R3: Issue order is all class-8 pairs, then all class-16 pairs, then all class-32 pairs. Within a class, pairs keep their arrival order. out_tag equals the arrival index of the pair in its batch, counted from 0.
- R4: Every accepted pair is issued exactly once and with its operands unchanged. Classes with no pairs are skipped. After the last pair, in_ready returns high.
- R5: Policy A (mode=0, and also the reserved mode=3): class 8/16/32 use voltage codes V8/V16/V32 and frequency codes F8/F16/F32. The defaults are voltage 3/5/7 and frequency 9/6/3.
- R6: Policy B (mode=1): the voltage code is V32 for every class, and the frequency code is the policy-A code of the class.
- R7: Policy C (mode=2): the voltage code is V32 for every class, and the frequency code is FTOP minus the policy-A code, with FTOP=9. The frequency code k means a clock of 5*(k+1) MHz.
- R8: vf_update is high for exactly one cycle each time a group begins with a voltage or frequency code that differs from the codes already held. The codes change only in that cycle. After reset both codes are 0.
- R9: out_valid is low in the vf_update cycle and in the cycle after it. The group's first pair is issued two cycles after vf_update.
- R10: After reset, in_ready=1, out_valid=0 and vf_update=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Operating-point policy: 0=A, 1=B, 2=C, 3=A |
| in_valid | input | 1 | Incoming pair valid |
| in_last | input | 1 | Pair closes the batch |
| in_a | input | DW | First operand |
| in_b | input | DW | Second operand |
| in_ready | output | 1 | Unit is collecting |
| out_valid | output | 1 | Issued pair valid |
| out_a | output | DW | Issued first operand |
| out_b | output | DW | Issued second operand |
| out_tag | output | TW | Arrival index of the issued pair |
| out_prec | output | 2 | Class of the issued pair |
| volt_code | output | VW | Minimum-voltage code |
| freq_code | output | 4 | Frequency code |
| vf_update | output | 1 | Operating point changed this cycle |

## Verification
Random batches mix the three classes and vary in size and policy. They show whether grouping keeps arrival order inside a class and whether the tags follow their operands. Directed batches do three things:

- They place operands just inside and just outside the signed 8- and 16-bit limits, which separates off-by-one errors in the range detector.
- They repeat a single-class batch, which shows whether the strobe fires when the codes do not change.
- They fill the buffer without a last flag, and offer pairs during issue, to show the close-on-full rule and that busy-time input is ignored.

Running all three policies on the same mixed batch separates the voltage rule from the frequency rule.

// File: rtl/opsched_pkg.sv
package opsched_pkg;
   typedef enum logic [1:0] {
      PREC8  = 2'd0,
      PREC16 = 2'd1,
      PREC32 = 2'd2
   } prec_e;

   typedef enum logic [2:0] {
      S_COLL,
      S_PICK,
      S_VF,
      S_SETTLE,
      S_ISSUE
   } sched_state_e;

   localparam int NCLS = 3;
endpackage

// File: rtl/opsched_range.sv
module opsched_range
   import opsched_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output prec_e         prec
);
   generate
      if (DW < 17) begin : g_bad_width
         $error("opsched_range: DW must exceed 16");
      end
   endgenerate

   function automatic logic fits(input logic [DW-1:0] v, input int bits);
      logic all1, all0;
      all1 = 1'b1;
      all0 = 1'b1;
      for (int i = 0; i < DW; i++) begin
         if (i >= bits - 1) begin
            all1 = all1 & v[i];
            all0 = all0 & ~v[i];
         end
      end
      return all1 | all0;
   endfunction

   always_comb begin
      if (fits(a, 8) && fits(b, 8))        prec = PREC8;
      else if (fits(a, 16) && fits(b, 16)) prec = PREC16;
      else                                 prec = PREC32;
   end
endmodule

// File: rtl/opsched_lut.sv
module opsched_lut
   import opsched_pkg::*;
#(
   parameter int VW   = 3,
   parameter int FW   = 4,
   parameter int V8   = 3,
   parameter int V16  = 5,
   parameter int V32  = 7,
   parameter int F8   = 9,
   parameter int F16  = 6,
   parameter int F32  = 3,
   parameter int FTOP = 9
) (
   input  prec_e          cls,
   input  logic [1:0]     mode,
   output logic [VW-1:0]  volt,
   output logic [FW-1:0]  freq
);
   localparam logic [FW-1:0] FTOP_L = FW'(FTOP);

   generate
      if (FTOP > (1 << FW) - 1) begin : g_bad_ftop
         $error("opsched_lut: FTOP does not fit FW");
      end
      if (F8 > FTOP || F16 > FTOP || F32 > FTOP) begin : g_bad_freq
         $error("opsched_lut: frequency code above FTOP");
      end
      if (V8 > V16 || V16 > V32 || V32 > (1 << VW) - 1) begin : g_bad_volt
         $error("opsched_lut: voltage codes must rise with precision and fit VW");
      end
   endgenerate

   logic [VW-1:0] base_v;
   logic [FW-1:0] base_f;

   always_comb begin
      unique case (cls)
         PREC8:   begin base_v = VW'(V8);  base_f = FW'(F8);  end
         PREC16:  begin base_v = VW'(V16); base_f = FW'(F16); end
         default: begin base_v = VW'(V32); base_f = FW'(F32); end
      endcase
   end

   // B and C pin voltage at the widest class so every class meets timing
   always_comb begin
      unique case (mode)
         2'd1:    begin volt = VW'(V32); freq = base_f;          end
         2'd2:    begin volt = VW'(V32); freq = FTOP_L - base_f; end
         default: begin volt = base_v;   freq = base_f;          end
      endcase
   end
endmodule

// File: rtl/opsched_buf.sv
module opsched_buf
   import opsched_pkg::*;
#(
   parameter int DW = 32,
   parameter int D  = 8,
   localparam int TW = (D > 1) ? $clog2(D) : 1,
   localparam int CW = $clog2(D + 1),
   localparam int EW = 2 * DW + TW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          wr_en,
   input  prec_e         wr_cls,
   input  logic [EW-1:0] wr_data,
   input  prec_e         rd_cls,
   input  logic [CW-1:0] rd_idx,
   output logic [EW-1:0] rd_data,
   output logic [CW-1:0] cnt [NCLS]
);
   generate
      if (D < 2) begin : g_bad_depth
         $error("opsched_buf: D must be at least 2");
      end
   endgenerate

   logic [EW-1:0] rdata [NCLS];

   for (genvar c = 0; c < NCLS; c++) begin : g_region
      logic [EW-1:0] mem [D];
      logic          hit;
      assign hit = wr_en && (wr_cls == prec_e'(c));

      always_ff @(posedge clk) begin
         if (!rst_n || clear) begin
            cnt[c] <= '0;
         end else if (hit) begin
            cnt[c] <= cnt[c] + 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (hit) mem[cnt[c][TW-1:0]] <= wr_data;
      end

      assign rdata[c] = mem[rd_idx[TW-1:0]];

      p_no_overflow_r2 : assert property (@(posedge clk) disable iff (!rst_n)
         hit |-> (cnt[c] < CW'(D)));
   end

   assign rd_data = rdata[rd_cls];
endmodule

// File: rtl/opsched_top.sv
module opsched_top
   import opsched_pkg::*;
#(
   parameter int DW   = 32,
   parameter int D    = 8,
   parameter int VW   = 3,
   parameter int V8   = 3,
   parameter int V16  = 5,
   parameter int V32  = 7,
   parameter int F8   = 9,
   parameter int F16  = 6,
   parameter int F32  = 3,
   parameter int FTOP = 9,
   localparam int TW  = (D > 1) ? $clog2(D) : 1,
   localparam int CW  = $clog2(D + 1),
   localparam int EW  = 2 * DW + TW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    mode,
   input  logic          in_valid,
   input  logic          in_last,
   input  logic [DW-1:0] in_a,
   input  logic [DW-1:0] in_b,
   output logic          in_ready,
   output logic          out_valid,
   output logic [DW-1:0] out_a,
   output logic [DW-1:0] out_b,
   output logic [TW-1:0] out_tag,
   output logic [1:0]    out_prec,
   output logic [VW-1:0] volt_code,
   output logic [3:0]    freq_code,
   output logic          vf_update
);
   sched_state_e  state;
   prec_e         cur_cls, in_cls, found_cls;
   logic          found_ok;
   logic [CW-1:0] total, rd_idx;
   logic [CW-1:0] cnt [NCLS];
   logic [EW-1:0] rd_data;
   logic [VW-1:0] lut_v;
   logic [3:0]    lut_f;
   logic          accept, closing, clear, last_of_group;

   opsched_range #(.DW(DW)) i_range (
      .a(in_a), .b(in_b), .prec(in_cls)
   );

   opsched_lut #(
      .VW(VW), .FW(4), .V8(V8), .V16(V16), .V32(V32),
      .F8(F8), .F16(F16), .F32(F32), .FTOP(FTOP)
   ) i_lut (
      .cls(found_cls), .mode(mode), .volt(lut_v), .freq(lut_f)
   );

   opsched_buf #(.DW(DW), .D(D)) i_buf (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .wr_en(accept), .wr_cls(in_cls),
      .wr_data({in_a, in_b, total[TW-1:0]}),
      .rd_cls(cur_cls), .rd_idx(rd_idx),
      .rd_data(rd_data), .cnt(cnt)
   );

   assign in_ready = (state == S_COLL);
   assign accept   = in_ready && in_valid;
   assign closing  = accept && (in_last || (total == CW'(D - 1)));

   // lowest non-empty class at or above the current one
   always_comb begin
      found_ok  = 1'b0;
      found_cls = cur_cls;
      for (int c = NCLS - 1; c >= 0; c--) begin
         if ((c >= int'(cur_cls)) && (cnt[c] != '0)) begin
            found_ok  = 1'b1;
            found_cls = prec_e'(c);
         end
      end
   end

   assign last_of_group = (rd_idx == cnt[cur_cls] - 1'b1);
   assign clear = ((state == S_ISSUE) && last_of_group && (cur_cls == PREC32))
               || ((state == S_PICK) && !found_ok);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= S_COLL;
         cur_cls   <= PREC8;
         total     <= '0;
         rd_idx    <= '0;
         volt_code <= '0;
         freq_code <= '0;
      end else begin
         unique case (state)
            S_COLL: begin
               if (accept) total <= total + 1'b1;
               if (closing) begin
                  state   <= S_PICK;
                  total   <= '0;
                  cur_cls <= PREC8;
               end
            end
            S_PICK: begin
               rd_idx <= '0;
               if (!found_ok) begin
                  state   <= S_COLL;
                  cur_cls <= PREC8;
               end else begin
                  cur_cls <= found_cls;
                  if ((lut_v != volt_code) || (lut_f != freq_code)) begin
                     volt_code <= lut_v;
                     freq_code <= lut_f;
                     state     <= S_VF;
                  end else begin
                     state <= S_ISSUE;
                  end
               end
            end
            S_VF:     state <= S_SETTLE;
            S_SETTLE: state <= S_ISSUE;
            S_ISSUE: begin
               rd_idx <= rd_idx + 1'b1;
               if (last_of_group) begin
                  if (cur_cls == PREC32) begin
                     state   <= S_COLL;
                     cur_cls <= PREC8;
                  end else begin
                     state   <= S_PICK;
                     cur_cls <= prec_e'(cur_cls + 2'd1);
                  end
               end
            end
            default: state <= S_COLL;
         endcase
      end
   end

   assign vf_update = (state == S_VF);
   assign out_valid = (state == S_ISSUE);
   assign out_prec  = cur_cls;
   assign {out_a, out_b, out_tag} = rd_data;

   p_vf_quiet_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      vf_update |-> !out_valid);
   p_settle_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      vf_update |=> !out_valid);
   p_code_change_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      ((volt_code != $past(volt_code)) || (freq_code != $past(freq_code))) |-> vf_update);
   p_busy_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);
   p_order_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid)) |-> (out_prec >= $past(out_prec)));
   p_freq_range_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      freq_code <= 4'(FTOP));
endmodule

// File: tb/test_opsched_top.sv
module test_opsched_top;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int D  = 8;
   localparam int TW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode = 2'd0;
   logic          in_valid = 1'b0;
   logic          in_last = 1'b0;
   logic [DW-1:0] in_a = '0;
   logic [DW-1:0] in_b = '0;
   logic          in_ready, out_valid, vf_update;
   logic [DW-1:0] out_a, out_b;
   logic [TW-1:0] out_tag;
   logic [1:0]    out_prec;
   logic [2:0]    volt_code;
   logic [3:0]    freq_code;

   opsched_top i_opsched_top (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .in_valid(in_valid), .in_last(in_last), .in_a(in_a), .in_b(in_b),
      .in_ready(in_ready), .out_valid(out_valid), .out_a(out_a), .out_b(out_b),
      .out_tag(out_tag), .out_prec(out_prec), .volt_code(volt_code),
      .freq_code(freq_code), .vf_update(vf_update)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   typedef struct {
      logic [31:0] a;
      logic [31:0] b;
      int tag;
      int cls;
      int v;
      int f;
   } exp_t;

   exp_t q[$];
   int checks = 0, failures = 0;
   int cyc = 0, last_vf = 0, vf_pulses = 0;
   bit vf_seen = 0, mon_on = 0;
   int model_v = 0, model_f = 0;
   logic [31:0] ba [D];
   logic [31:0] bb [D];

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit fits(input logic [31:0] v, input int bits);
      longint s = longint'($signed(v));
      longint lim = longint'(1) << (bits - 1);
      return (s >= -lim) && (s < lim);
   endfunction

   function automatic int cls_of(input logic [31:0] a, input logic [31:0] b);
      if (fits(a, 8) && fits(b, 8)) return 0;
      if (fits(a, 16) && fits(b, 16)) return 1;
      return 2;
   endfunction

   function automatic int exp_v(input int c, input int m);
      if (m == 1 || m == 2) return 7;
      return (c == 0) ? 3 : (c == 1) ? 5 : 7;
   endfunction

   function automatic int exp_f(input int c, input int m);
      int fa = (c == 0) ? 9 : (c == 1) ? 6 : 3;
      return (m == 2) ? 9 - fa : fa;
   endfunction

   function automatic logic [31:0] rnd_val(input int c);
      logic [31:0] v;
      case (c)
         0: v = 32'($urandom_range(0, 255)) - 32'd128;
         1: v = 32'($urandom_range(128, 32767));
         default: v = 32'($urandom_range(32768, 32'h7FFFFFFF));
      endcase
      if (c != 0 && $urandom_range(0, 1) == 1) v = -v;
      return v;
   endfunction

   // monitor: sample between edges
   always @(negedge clk) begin
      if (mon_on) begin
         cyc++;
         if (vf_update) begin
            vf_pulses++;
            last_vf = cyc;
            vf_seen = 1;
            chk(!out_valid, "R9 valid during vf_update", out_valid, 0);
         end
         if (out_valid) begin
            exp_t e;
            chk(!in_ready, "R2 in_ready during issue", in_ready, 0);
            if (vf_seen) begin
               chk(cyc - last_vf == 2, "R9 settle distance", cyc - last_vf, 2);
               vf_seen = 0;
            end
            if (q.size() == 0) begin
               chk(0, "R4 unexpected issue", out_tag, -1);
            end else begin
               e = q.pop_front();
               chk(out_a == e.a, "R4 operand a", out_a, e.a);
               chk(out_b == e.b, "R4 operand b", out_b, e.b);
               chk(int'(out_tag) == e.tag, "R3 tag/order", out_tag, e.tag);
               chk(int'(out_prec) == e.cls, "R1 class", out_prec, e.cls);
               chk(int'(volt_code) == e.v, "R5/R6/R7 voltage code", volt_code, e.v);
               chk(int'(freq_code) == e.f, "R5/R6/R7 frequency code", freq_code, e.f);
            end
         end
      end
   end

   task automatic send(input logic [31:0] a, input logic [31:0] b, input bit last);
      @(negedge clk);
      in_valid = 1'b1; in_a = a; in_b = b; in_last = last;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
   endtask

   // n pairs from ba/bb; use_last=0 relies on close-at-D (R2)
   task automatic run_batch(input int n, input int m, input bit use_last, input bit junk);
      int pulses0, exp_p;
      mode = 2'(m);
      pulses0 = vf_pulses;
      for (int i = 0; i < n; i++) send(ba[i], bb[i], use_last && (i == n - 1));
      exp_p = 0;
      for (int c = 0; c < 3; c++) begin
         bit any = 0;
         for (int i = 0; i < n; i++) begin
            if (cls_of(ba[i], bb[i]) == c) begin
               exp_t e;
               e.a = ba[i]; e.b = bb[i]; e.tag = i; e.cls = c;
               e.v = exp_v(c, m); e.f = exp_f(c, m);
               q.push_back(e);
               any = 1;
            end
         end
         if (any && (exp_v(c, m) != model_v || exp_f(c, m) != model_f)) begin
            exp_p++;
            model_v = exp_v(c, m);
            model_f = exp_f(c, m);
         end
      end
      @(negedge clk);
      in_last = 1'b0;
      if (junk) begin
         // R2: offered while busy, must never appear
         in_a = 32'h1234_5678; in_b = 32'h0000_0005;
         for (int k = 0; k < 3; k++) begin
            chk(!in_ready, "R2 ready low after close", in_ready, 0);
            @(negedge clk);
         end
      end
      in_valid = 1'b0;
      while (q.size() != 0 || !in_ready) @(negedge clk);
      @(negedge clk);
      chk(in_ready, "R4 ready after batch", in_ready, 1);
      chk(vf_pulses - pulses0 == exp_p, "R8 vf_update pulse count", vf_pulses - pulses0, exp_p);
      chk(q.size() == 0, "R4 all pairs issued", q.size(), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk(in_ready, "R10 reset in_ready", in_ready, 1);
      chk(!out_valid, "R10 reset out_valid", out_valid, 0);
      chk(!vf_update, "R10 reset vf_update", vf_update, 0);
      chk(volt_code == 0 && freq_code == 0, "R8 reset codes", {volt_code, freq_code}, 0);
      mon_on = 1;

      // R1 boundaries, R5 policy A
      ba[0] = 32'd127;          bb[0] = 32'hFFFF_FF80;
      ba[1] = 32'd128;          bb[1] = 32'd0;
      ba[2] = 32'hFFFF_FF7F;    bb[2] = 32'd1;
      ba[3] = 32'd32767;        bb[3] = 32'hFFFF_8000;
      ba[4] = 32'd32768;        bb[4] = 32'd0;
      ba[5] = 32'd5;            bb[5] = 32'hFFFF_7FFF;
      ba[6] = 32'hFFFF_FFFF;    bb[6] = 32'd3;
      run_batch(7, 0, 1, 1);
      // same mix under R6 and R7
      run_batch(7, 1, 1, 0);
      run_batch(7, 2, 1, 0);
      // R8: single class twice, second brings no change
      for (int i = 0; i < 3; i++) begin ba[i] = 32'd200 + 32'(i); bb[i] = 32'd1; end
      run_batch(3, 0, 1, 0);
      run_batch(3, 0, 1, 0);
      // R2: full buffer without last; R5 reserved mode 3
      for (int i = 0; i < D; i++) begin ba[i] = rnd_val(i % 3); bb[i] = rnd_val(0); end
      run_batch(D, 3, 0, 1);
      // single pair
      ba[0] = 32'h8000_0000; bb[0] = 32'd0;
      run_batch(1, 2, 1, 0);
      // random batches
      for (int t = 0; t < 40; t++) begin
         int n = $urandom_range(1, D);
         for (int i = 0; i < n; i++) begin
            ba[i] = rnd_val($urandom_range(0, 2));
            bb[i] = rnd_val($urandom_range(0, 2));
         end
         run_batch(n, $urandom_range(0, 3), (n != D) || ($urandom_range(0, 1) == 1), t % 5 == 0);
      end
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule